// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

An eight-pin general-purpose I/O port controlled through a small synchronous register bus. Each pin has a direction bit, an output latch bit, a pull-up request and, for the five lowest pins, an analog-select bit. The pins appear as separate input, output and output-enable signals, so the pad ring does the tri-stating. Inputs are resynchronised by two flops before any logic uses them.

The upper four pins watch for change. Each pin configured as an input is compared with a snapshot of its synchronised value. The snapshot is refreshed whenever software reads or writes the port register. A difference on any watched pin sets a sticky change flag. The flag drives a wake request and, when enabled, an interrupt. Software cannot clear the flag while the difference remains, so the usual handler sequence is: read the port, then clear the flag.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset: the direction register reads 0xFF (all pins inputs), the latch reads 0x00, the control register reads 0x80, the analog-select register reads 0x1F, and pin_oe, pin_pu, irq and wake are all 0.
- R2: A write to offset 0 or offset 1 loads the output latch, which appears on pin_out at the next clock edge. pin_oe[i] is 1 exactly when direction bit i (offset 2) is 0.
- R3: A read at offset 1 returns the latch contents, not the pin levels.
- R4: A read at offset 0 returns the pin levels in the same cycle as the access. A pin change is visible in this read two clock edges after it is applied.
- R5: The flag (control offset 3, bit 0) is set on the third clock edge after an upper pin (7..4) that is an input changes away from its snapshot. Changes on pins 3..0 never set it.
- R6: An upper pin whose direction bit is 0 (output) never sets the flag, even when its level toggles.
- R7: Writing control bit 0 as 0 clears the flag only when no mismatch exists. While a mismatch persists, the set wins and the flag stays 1. A read or write of offset 0 refreshes the snapshot, which ends the mismatch. Writing bit 0 as 1 never sets the flag.
- R8: wake equals the flag, and irq equals the flag ANDed with the interrupt enable (control bit 1).
- R9: pin_pu[i] is 1 when control bit 7 (active-low pull-up enable) is 0 and pin i is an input. pin_pu[i] is 0 otherwise.
- R10: Bits 4..0 of offset 4 are the analog selects, and they drive pin_ana. A pin with its analog select set reads 0 at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels (latch) |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Weak pull-up enables |
| pin_ana | output | 5 | Analog select for pins 4..0 |
| irq | output | 1 | Change interrupt |
| wake | output | 1 | Wake request |

## Verification
Register writes take effect at the clock edge that ends the access. Reads return data combinationally within the access cycle. A pin change reaches the port read after two edges and reaches the flag, wake and irq after three edges. The bench drives every stimulus on a falling edge and samples the outputs on falling edges. For a pin change it checks the flag still low after two rising edges and high after the third, so an early or late flag is caught. Flag-clear checks sample the flag on the falling edge right after the clearing write.

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int W      = 8,
  parameter int CHG_LO = 4,
  parameter int ANA_N  = 5,
  parameter int AW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_pu,
  output logic [ANA_N-1:0] pin_ana,
  output logic          irq,
  output logic          wake
);
  localparam int CW = W - CHG_LO;
  localparam logic [AW-1:0] A_PORT = AW'(0);
  localparam logic [AW-1:0] A_LAT  = AW'(1);
  localparam logic [AW-1:0] A_DIR  = AW'(2);
  localparam logic [AW-1:0] A_CTRL = AW'(3);
  localparam logic [AW-1:0] A_ANA  = AW'(4);

  logic [W-1:0]     sync1, sync2, lat, dir;
  logic [CW-1:0]    snap;
  logic [ANA_N-1:0] ana;
  logic             flag, ie, pu_n;

  wire wr = bus_sel & bus_we;
  wire [W-1:0]  ana_mask = {{(W-ANA_N){1'b0}}, ana};
  wire [W-1:0]  port_val = sync2 & ~ana_mask;
  wire          snap_upd = bus_sel & (bus_addr == A_PORT);
  wire [CW-1:0] mm_bits  = (sync2[W-1:CHG_LO] ^ snap) & dir[W-1:CHG_LO];
  wire          mm       = |mm_bits;
  wire          clr_req  = wr & (bus_addr == A_CTRL) & ~bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat  <= '0;
      dir  <= '1;
      ana  <= '1;
      ie   <= 1'b0;
      pu_n <= 1'b1;
    end else if (wr) begin
      case (bus_addr)
        A_PORT, A_LAT: lat <= bus_wdata;
        A_DIR:         dir <= bus_wdata;
        A_CTRL: begin
          ie   <= bus_wdata[1];
          pu_n <= bus_wdata[W-1];
        end
        A_ANA:         ana <= bus_wdata[ANA_N-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap <= '0;
    else if (snap_upd) snap <= sync2[W-1:CHG_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (mm)      flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        A_PORT: bus_rdata = port_val;
        A_LAT:  bus_rdata = lat;
        A_DIR:  bus_rdata = dir;
        A_CTRL: bus_rdata = {pu_n, {(W-3){1'b0}}, ie, flag};
        A_ANA:  bus_rdata = ana_mask;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = lat;
  assign pin_oe  = ~dir;
  assign pin_pu  = pu_n ? '0 : dir;
  assign pin_ana = ana;
  assign wake    = flag;
  assign irq     = flag & ie;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
  parameter int W      = 8,
  parameter int CHG_LO = 4,
  parameter int AW     = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [AW-1:0]       bus_addr,
  input logic [W-1:0]        bus_wdata,
  input logic [W-1:0]        pin_out,
  input logic [W-1:0]        pin_oe,
  input logic [W-1:0]        pin_pu,
  input logic                irq,
  input logic                wake,
  input logic                mm,
  input logic [W-1:0]        sync2,
  input logic [W-CHG_LO-1:0] snap
);
  wire clr_wr  = bus_sel & bus_we & (bus_addr == AW'(3)) & ~bus_wdata[0];
  wire lat_wr  = bus_sel & bus_we & (bus_addr <= AW'(1));
  wire snap_ev = bus_sel & (bus_addr == AW'(0));

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_pu == '0 && !wake && !irq));

  assert_latch_to_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lat_wr |=> pin_out == $past(bus_wdata));

  assert_snap_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snap_ev |=> snap == $past(sync2[W-1:CHG_LO]));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !clr_wr) |=> wake);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mm && clr_wr) |=> wake);

  assert_clear_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mm && clr_wr) |=> !wake);

  assert_irq_needs_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake);

  assert_pu_off_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(W), .CHG_LO(CHG_LO), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .pin_pu(pin_pu), .irq(irq), .wake(wake),
  .mm(mm), .sync2(sync2), .snap(snap)
);

// File: tb/sim_gpio_chg_port.sv
`timescale 1ns/1ps
module sim_gpio_chg_port;
  logic       clk = 0, rst_n = 0;
  logic       bus_sel = 0, bus_we = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] ext = '0, pin_in, pin_out, pin_oe, pin_pu;
  logic [4:0] pin_ana;
  logic       irq, wake;
  int checks = 0, failures = 0;
  logic [7:0] rd;

  always #2 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_chg_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .pin_ana(pin_ana), .irq(irq), .wake(wake)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rdreg(logic [2:0] a, output logic [7:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rdreg(2, rd); chk("R1 dir", rd, 8'hFF);
    rdreg(1, rd); chk("R1 latch", rd, 8'h00);
    rdreg(3, rd); chk("R1 ctrl", rd, 8'h80);
    rdreg(4, rd); chk("R1 ana", rd, 8'h1F);
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 pu", pin_pu, 8'h00);
    chk("R1 irq/wake", {6'b0, irq, wake}, 8'h00);
  endtask

  task automatic t_dir_latch;
    wr(1, 8'hA5);
    chk("R2 pin_out", pin_out, 8'hA5);
    wr(2, 8'hF0);
    chk("R2 oe", pin_oe, 8'h0F);
    ext = 8'h00;
    rdreg(1, rd); chk("R3 latch not pins", rd, 8'hA5);
    wr(0, 8'h3C);
    rdreg(1, rd); chk("R2 port write loads latch", rd, 8'h3C);
    wr(2, 8'hFF);
    chk("R2 oe all inputs", pin_oe, 8'h00);
  endtask

  task automatic t_port_read;
    wr(4, 8'h00);
    chk("R10 pin_ana", {3'b0, pin_ana}, 8'h00);
    ext = 8'h5A;
    edges(1);
    rdreg(0, rd); chk("R4 one edge old", rd, 8'h00);
    rdreg(0, rd); chk("R4 two edges new", rd, 8'h5A);
    wr(4, 8'h1F);
    rdreg(0, rd); chk("R10 analog reads 0", rd, 8'h40);
    chk("R10 pin_ana", {3'b0, pin_ana}, 8'h1F);
  endtask

  task automatic t_change;
    rdreg(0, rd);
    wr(3, 8'h82);
    chk("R7 clear with no mismatch", {7'b0, wake}, 8'h00);
    wr(3, 8'h83);
    chk("R7 write 1 no set", {7'b0, wake}, 8'h00);
    ext = 8'h7A;
    edges(2);
    chk("R5 flag not early", {7'b0, wake}, 8'h00);
    edges(1);
    chk("R5 flag third edge", {7'b0, wake}, 8'h01);
    chk("R8 irq enabled", {7'b0, irq}, 8'h01);
    wr(3, 8'h82);
    chk("R7 set wins over clear", {7'b0, wake}, 8'h01);
    rdreg(0, rd);
    wr(3, 8'h82);
    chk("R7 clear after port read", {7'b0, wake}, 8'h00);
    ext = 8'h7C;
    edges(4);
    chk("R5 low pins ignored", {7'b0, wake}, 8'h00);
    ext = 8'h6C;
    edges(3);
    chk("R5 pin4 sets", {7'b0, wake}, 8'h01);
    wr(3, 8'h80);
    chk("R8 irq masked", {6'b0, irq, wake}, 8'h01);
    wr(0, 8'h3C);
    wr(3, 8'h80);
    chk("R7 clear after port write", {7'b0, wake}, 8'h00);
  endtask

  task automatic t_out_excl;
    wr(2, 8'h7F);
    rdreg(0, rd);
    wr(3, 8'h80);
    chk("R6 start clear", {7'b0, wake}, 8'h00);
    wr(1, 8'hBC);
    edges(5);
    chk("R6 output pin7 toggle ignored", {7'b0, wake}, 8'h00);
    rdreg(0, rd); chk("R6 pin7 driven high", rd & 8'h80, 8'h80);
    ext = 8'hEC;
    edges(5);
    chk("R6 ext on output pin ignored", {7'b0, wake}, 8'h00);
  endtask

  task automatic t_pullup;
    wr(3, 8'h00);
    chk("R9 pu inputs only", pin_pu, 8'h7F);
    wr(2, 8'h0F);
    chk("R9 pu follows dir", pin_pu, 8'h0F);
    wr(3, 8'h80);
    chk("R9 pu disabled", pin_pu, 8'h00);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_dir_latch;
    t_port_read;
    t_change;
    t_out_excl;
    t_pullup;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule